// File: doc/BRIEF.md
# SPI Controller Status and Error-Flag Register

This block holds the hardware-maintained status of a serial peripheral interface controller: a run/configuration mode flag, a master-select flag, a software-only mode-error flag and five error flags captured from the serial engine: transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Software never writes these flags directly. It writes a separate command word, and each flag has its own set bit and its own clear bit in that word. One write can therefore change any chosen group of flags without first reading the register back.

The serial engine reports each error as a one-cycle pulse. A pulse is captured only while the matching error-enable bit from the control register is 1. The block assembles a read-only status word that also carries the engine's busy indication. It raises an error interrupt while any error flag is set and the interrupt enable is on. Flag updates take effect on the clock edge after the write or pulse. The busy bit and the interrupt follow their inputs in the same cycle.

Top module: `ssr_status_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every flag is cleared, whatever the other inputs are. After that edge, `status_o` holds only the busy bit and `err_irq_o` is 0.
- R2: A command write with bit 1 set moves the block to run mode: status bit 0 and `run_mode_o` read 1 after the edge. A write with bit 0 set returns it to configuration mode: status bit 0 reads 0.
- R3: Command bit 3 sets the master-select flag and command bit 2 clears it. The flag appears on status bit 1 and on `master_o`.
- R4: Each error flag has a fixed clear/set pair of command bits and a fixed status bit. Transmit overflow is cleared by bit 8, set by bit 12 and shown at status 8. Receive overflow uses 9/13 and status 9. Abort uses 10/14 and status 10. Transmit underflow uses 11/15 and status 11. Receive underflow uses 4/5 and status 12. The mode error uses 6/7 and status 14.
- R5: The command value 0x0F50 clears all six error flags in one write and leaves the mode and master-select flags unchanged.
- R6: A write that asserts both the set bit and the clear bit of one flag leaves that flag unchanged.
- R7: Engine error pulses `err_evt[0..4]` map to status bits 8..12 (bit = 8 + index). A pulse sets its flag only when `err_en` at the same index is 1; otherwise it has no effect.
- R8: An enabled engine pulse wins over a software clear of the same flag in the same cycle, so the flag ends set.
- R9: `err_irq_o` equals `err_irq_en` ANDed with the OR of the six error flags (status bits 8..12 and 14).
- R10: Status bit 13 follows `busy_in` in the same cycle. Status bits 2..7 and 15 always read 0.
- R11: `cmd_data` has no effect while `cmd_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_data | input | 16 | Command word of paired set/clear bits |
| err_evt | input | 5 | One-cycle error pulses from the serial engine |
| err_en | input | 5 | Error-capture enables from the control register |
| err_irq_en | input | 1 | Error interrupt enable |
| busy_in | input | 1 | Engine busy indication |
| status_o | output | 16 | Assembled status word |
| run_mode_o | output | 1 | 1 = run mode, 0 = configuration mode |
| master_o | output | 1 | Master-select flag |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
Several properties are checked on every cycle: the interrupt matches the enabled OR of the error flags; busy is mirrored; an error flag never rises without a write or an enabled pulse; an enabled pulse always leaves its flag set; a write with both bits of the enable pair leaves the mode flag unchanged; and the bulk clear value clears every error flag. The exact mapping of every command bit pair to its status bit, the master-select pair, the ignored data while the strobe is low, and the reset behaviour under active inputs are shown only by the bench's scenarios. Those scenarios compare the whole status word against an independent model after each edge.

// File: rtl/ssr_pkg.sv
// Package: shared constants and bit-position helpers for the SPI status
// register. Assumes a 16-bit command word and a 16-bit status word; the
// positions below are decoded by software and the serial engine, so they
// are fixed behaviour rather than layout choices.
package ssr_pkg;

    localparam int CMD_W    = 16;
    localparam int STAT_W   = 16;
    localparam int N_FLAGS  = 8;
    localparam int N_HW_ERR = 5;
    localparam int BUSY_POS = 13;

    // Internal flag indices
    localparam int F_EN  = 0;   // run/configuration mode
    localparam int F_MS  = 1;   // master select
    localparam int F_RUF = 2;   // receive underflow
    localparam int F_MER = 3;   // mode error (software only)
    localparam int F_TXE = 4;   // transmit overflow
    localparam int F_RXE = 5;   // receive overflow
    localparam int F_ABT = 6;   // abort
    localparam int F_TUF = 7;   // transmit underflow

    // Flags that count as errors (everything except mode and master select)
    localparam logic [N_FLAGS-1:0] ERR_FLAG_MASK = 8'hFC;

    // Command bit that sets a flag
    function automatic int set_pos(input int f);
        case (f)
            F_EN:    return 1;
            F_MS:    return 3;
            F_RUF:   return 5;
            F_MER:   return 7;
            F_TXE:   return 12;
            F_RXE:   return 13;
            F_ABT:   return 14;
            default: return 15;
        endcase
    endfunction

    // Command bit that clears a flag
    function automatic int clr_pos(input int f);
        case (f)
            F_EN:    return 0;
            F_MS:    return 2;
            F_RUF:   return 4;
            F_MER:   return 6;
            F_TXE:   return 8;
            F_RXE:   return 9;
            F_ABT:   return 10;
            default: return 11;
        endcase
    endfunction

    // Status word bit that shows a flag
    function automatic int stat_pos(input int f);
        case (f)
            F_EN:    return 0;
            F_MS:    return 1;
            F_RUF:   return 12;
            F_MER:   return 14;
            F_TXE:   return 8;
            F_RXE:   return 9;
            F_ABT:   return 10;
            default: return 11;
        endcase
    endfunction

    // Engine pulse index feeding a flag, -1 when software-only
    function automatic int hw_idx(input int f);
        case (f)
            F_TXE:   return 0;
            F_RXE:   return 1;
            F_ABT:   return 2;
            F_TUF:   return 3;
            F_RUF:   return 4;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/ssr_cmd_decode.sv
// Module: splits a command write into per-flag set and clear strobes.
// Assumes the command word is qualified by a single write strobe; without
// the strobe no flag sees a request.
module ssr_cmd_decode
    import ssr_pkg::*;
#(
    parameter int CW = CMD_W,
    parameter int NF = N_FLAGS
) (
    input  logic          cmd_we,
    input  logic [CW-1:0] cmd_data,
    output logic [NF-1:0] set_req,
    output logic [NF-1:0] clr_req
);

    // Per-flag strobe extraction
    for (genvar gi = 0; gi < NF; gi++) begin : g_dec
        assign set_req[gi] = cmd_we & cmd_data[set_pos(gi)];
        assign clr_req[gi] = cmd_we & cmd_data[clr_pos(gi)];
    end

endmodule

// File: rtl/ssr_flag_cell.sv
// Module: one status flag. An engine event sets it with top priority;
// otherwise a lone set or a lone clear request applies, and a set together
// with a clear leaves it unchanged. Assumes synchronous active-low reset.
module ssr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic hw_hit,
    output logic flag_q
);

    // Flag update with event-over-software priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hw_hit) begin
            flag_q <= 1'b1;
        end else if (set_req && !clr_req) begin
            flag_q <= 1'b1;
        end else if (clr_req && !set_req) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ssr_irq_gen.sv
// Module: error interrupt request. ORs the flags selected by MASK and gates
// the result with the enable. Combinational, so the request tracks the
// registered flags in the same cycle.
module ssr_irq_gen #(
    parameter int              NF   = 8,
    parameter logic [NF-1:0]   MASK = '1
) (
    input  logic [NF-1:0] flags,
    input  logic          irq_en,
    output logic          irq
);

    // Gated OR of the error flags
    always_comb begin
        irq = irq_en & (|(flags & MASK));
    end

endmodule

// File: rtl/ssr_status_ctrl.sv
// Module: top of the SPI status/error register. Decodes paired set/clear
// command bits, captures enabled engine error pulses, assembles the status
// word and drives the error interrupt. Assumes engine pulses are one cycle
// wide and synchronous to clk.
module ssr_status_ctrl
    import ssr_pkg::*;
#(
    parameter int CW = CMD_W,
    parameter int SW = STAT_W,
    parameter int NE = N_HW_ERR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [CW-1:0] cmd_data,
    input  logic [NE-1:0] err_evt,
    input  logic [NE-1:0] err_en,
    input  logic          err_irq_en,
    input  logic          busy_in,
    output logic [SW-1:0] status_o,
    output logic          run_mode_o,
    output logic          master_o,
    output logic          err_irq_o
);

    localparam int NF = N_FLAGS;

    logic [NF-1:0] set_req;
    logic [NF-1:0] clr_req;
    logic [NF-1:0] hw_hit;
    logic [NF-1:0] flag_q;
    logic [NE-1:0] evt_gated;

    // Error pulses pass only where capture is enabled
    assign evt_gated = err_evt & err_en;

    ssr_cmd_decode #(.CW(CW), .NF(NF)) u_dec (
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .set_req  (set_req),
        .clr_req  (clr_req)
    );

    // Flag storage, one cell per flag with its engine source if any
    for (genvar gf = 0; gf < NF; gf++) begin : g_flag
        if (hw_idx(gf) >= 0) begin : g_src
            assign hw_hit[gf] = evt_gated[hw_idx(gf)];
        end else begin : g_nosrc
            assign hw_hit[gf] = 1'b0;
        end

        ssr_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_req[gf]),
            .clr_req (clr_req[gf]),
            .hw_hit  (hw_hit[gf]),
            .flag_q  (flag_q[gf])
        );
    end

    // Status word assembly from flags and live busy
    always_comb begin
        status_o = '0;
        for (int k = 0; k < NF; k++) begin
            status_o[stat_pos(k)] = flag_q[k];
        end
        status_o[BUSY_POS] = busy_in;
    end

    assign run_mode_o = flag_q[F_EN];
    assign master_o   = flag_q[F_MS];

    ssr_irq_gen #(.NF(NF), .MASK(ERR_FLAG_MASK)) u_irq (
        .flags  (flag_q),
        .irq_en (err_irq_en),
        .irq    (err_irq_o)
    );

endmodule

// File: rtl/ssr_status_chk.sv
// Checker: cycle properties of the status register, bound to the top.
module ssr_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we,
    input logic [15:0] cmd_data,
    input logic [4:0]  err_evt,
    input logic [4:0]  err_en,
    input logic        err_irq_en,
    input logic        busy_in,
    input logic [15:0] status_o,
    input logic        err_irq_o
);

    // R9: interrupt tracks the enabled OR of the error status bits
    a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o == (err_irq_en && ((status_o & 16'h5F00) != 16'h0000)));

    // R10: busy mirrored, reserved bits zero
    a_r10_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[13] == busy_in && (status_o & 16'h80FC) == 16'h0000);

    // R6: both halves of the mode pair leave the mode flag alone
    a_r6_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[1] && cmd_data[0]) |=> status_o[0] == $past(status_o[0]));

    // R2: a lone set of the mode flag enters run mode
    a_r2_run_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[1] && !cmd_data[0]) |=> status_o[0]);

    // R5: bulk clear with no enabled pulse empties every error flag
    a_r5_bulk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data == 16'h0F50 && (err_evt & err_en) == 5'd0)
        |=> (status_o & 16'h5F00) == 16'h0000 && status_o[1:0] == $past(status_o[1:0]));

    for (genvar gi = 0; gi < 5; gi++) begin : g_err
        // R8: an enabled pulse always leaves its flag set
        a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (err_evt[gi] && err_en[gi]) |=> status_o[8+gi]);

        // R7: an error flag rises only on a write or an enabled pulse
        a_r7_no_stray_rise: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_o[8+gi]) |-> ($past(cmd_we) || $past(err_evt[gi] && err_en[gi])));
    end

endmodule

bind ssr_status_ctrl ssr_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_data   (cmd_data),
    .err_evt    (err_evt),
    .err_en     (err_en),
    .err_irq_en (err_irq_en),
    .busy_in    (busy_in),
    .status_o   (status_o),
    .err_irq_o  (err_irq_o)
);

// File: tb/ssr_status_ctrl_tb_top.sv
// Scoreboard bench: a driver applies one cycle of stimulus, updates an
// independent model and queues the expected outputs; a monitor compares
// them one time step after the following clock edge.
module ssr_status_ctrl_tb_top;

    typedef struct {
        logic [15:0] stat;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [4:0]  err_evt = '0;
    logic [4:0]  err_en = '0;
    logic        err_irq_en = 1'b0;
    logic        busy_in = 1'b0;
    logic [15:0] status_o;
    logic        run_mode_o;
    logic        master_o;
    logic        err_irq_o;

    int n_chk = 0;
    int n_bad = 0;
    exp_t sb_q[$];
    logic [15:0] m_flags = '0;   // model of the flag bits of the status word
    logic [4:0]  cur_en = '0;
    logic        cur_ie = 1'b0;
    logic        cur_bz = 1'b0;

    always #10 clk = ~clk;

    ssr_status_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .cmd_data   (cmd_data),
        .err_evt    (err_evt),
        .err_en     (err_en),
        .err_irq_en (err_irq_en),
        .busy_in    (busy_in),
        .status_o   (status_o),
        .run_mode_o (run_mode_o),
        .master_o   (master_o),
        .err_irq_o  (err_irq_o)
    );

    // Driver: one stimulus cycle plus model update and expectation push
    task automatic step(input logic we, input logic [15:0] d, input logic [4:0] ev,
                        input string tag);
        int sp [8] = '{1, 3, 5, 7, 12, 13, 14, 15};
        int cp [8] = '{0, 2, 4, 6, 8, 9, 10, 11};
        int bp [8] = '{0, 1, 12, 14, 8, 9, 10, 11};
        exp_t e;
        @(posedge clk);
        #5;
        cmd_we = we; cmd_data = d; err_evt = ev;
        err_en = cur_en; err_irq_en = cur_ie; busy_in = cur_bz;
        for (int k = 0; k < 8; k++) begin
            logic s, c;
            s = we & d[sp[k]];
            c = we & d[cp[k]];
            if (s && !c) m_flags[bp[k]] = 1'b1;
            if (c && !s) m_flags[bp[k]] = 1'b0;
        end
        for (int j = 0; j < 5; j++) begin
            if (ev[j] && cur_en[j]) m_flags[8+j] = 1'b1;
        end
        e.stat = m_flags | (16'(cur_bz) << 13);
        e.irq  = cur_ie && ((m_flags & 16'h5F00) != 16'h0000);
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [15:0] d, input string tag);
        step(1'b1, d, 5'd0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 16'h0000, 5'd0, tag);
    endtask

    // Monitor: compare one time step after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (status_o !== e.stat || err_irq_o !== e.irq ||
                    run_mode_o !== e.stat[0] || master_o !== e.stat[1]) begin
                    n_bad++;
                    $display("FAIL %s: status=%h irq=%b run=%b ms=%b expected status=%h irq=%b",
                             e.tag, status_o, err_irq_o, run_mode_o, master_o, e.stat, e.irq);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Scenario sequence
    initial begin
        // R1: reset dominates an active write and pulses
        cmd_we = 1'b1; cmd_data = 16'hFFAA; err_evt = 5'h1F; err_en = 5'h1F;
        err_irq_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (status_o !== 16'h0000 || err_irq_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: status=%h irq=%b expected status=0000 irq=0",
                     status_o, err_irq_o);
        end
        #4;
        cmd_we = 1'b0; cmd_data = '0; err_evt = '0; err_en = '0; err_irq_en = 1'b0;
        rst_n = 1'b1;
        idle("R1 after release");

        // R2: run and configuration mode
        wr(16'h0002, "R2 enter run");
        wr(16'h0001, "R2 enter config");
        wr(16'h0002, "R2 run again");
        // R3: master select
        wr(16'h0008, "R3 master set");
        wr(16'h0004, "R3 master clear");
        wr(16'h0008, "R3 master set again");

        // R4: every error set then clear, one at a time
        wr(16'h1000, "R4 txovf set");
        wr(16'h2000, "R4 rxovf set");
        wr(16'h4000, "R4 abort set");
        wr(16'h8000, "R4 txunf set");
        wr(16'h0020, "R4 rxunf set");
        wr(16'h0080, "R4 mode err set");
        wr(16'h0100, "R4 txovf clear");
        wr(16'h0200, "R4 rxovf clear");
        wr(16'h0400, "R4 abort clear");
        wr(16'h0800, "R4 txunf clear");
        wr(16'h0010, "R4 rxunf clear");
        wr(16'h0040, "R4 mode err clear");

        // R5: bulk clear with run mode and master set
        wr(16'hF0A0, "R5 set all errors");
        wr(16'h0F50, "R5 bulk clear");

        // R6: paired requests hold
        wr(16'h0003, "R6 mode pair while run");
        wr(16'h0001, "R6 to config");
        wr(16'h0003, "R6 mode pair while config");
        wr(16'h1100, "R6 txovf pair while clear");
        wr(16'h1000, "R6 txovf set");
        wr(16'h1100, "R6 txovf pair while set");
        wr(16'h000C, "R6 master pair");
        wr(16'h0F50, "R6 cleanup");

        // R7: pulses ignored when capture disabled
        cur_en = 5'd0;
        step(1'b0, 16'h0000, 5'h1F, "R7 all pulses disabled");
        idle("R7 still clear");
        cur_en = 5'b10101;
        step(1'b0, 16'h0000, 5'h1F, "R7 partial enable");
        wr(16'h0F50, "R7 clear");
        cur_en = 5'h1F;
        for (int j = 0; j < 5; j++) begin
            step(1'b0, 16'h0000, 5'(1 << j), "R7 single pulse");
        end
        wr(16'h0F50, "R7 clear again");

        // R8: pulse and clear in the same cycle
        step(1'b1, 16'h0100, 5'b00001, "R8 txovf pulse vs clear");
        step(1'b1, 16'h0F50, 5'b10000, "R8 rxunf pulse vs bulk clear");
        wr(16'h0F50, "R8 clear");

        // R9: interrupt gating
        cur_ie = 1'b0;
        wr(16'h4000, "R9 flag set, irq disabled");
        cur_ie = 1'b1;
        idle("R9 irq enabled");
        wr(16'h0F50, "R9 flags cleared");
        wr(16'h0080, "R9 mode error raises irq");
        wr(16'h0040, "R9 mode error cleared");

        // R10: busy mirror
        cur_bz = 1'b1;
        idle("R10 busy high");
        cur_bz = 1'b0;
        idle("R10 busy low");

        // R11: data without strobe ignored
        step(1'b0, 16'hFFFF, 5'd0, "R11 no strobe all ones");
        step(1'b0, 16'h0F53, 5'd0, "R11 no strobe clears");

        repeat (3) @(posedge clk);
        #3;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule